// File: doc/BRIEF.md
# Multi-Pattern DFA Byte Matcher

This block checks packet payload against a whole set of signatures in a single pass. The signatures are first compiled into a deterministic automaton. Its transition table is loaded through a plain write port into one of two banks. Payload arrives as words of up to eight bytes. The block walks the automaton one byte at a time and makes exactly one transition per byte. When a transition lands in an output state, the block raises a one-cycle report carrying the pattern identifier and the index of the packet being scanned.

A signature can straddle two packets. To catch that case, every main packet is followed on the input by a spill segment, which is the head of the next packet. The walk carries its state into that segment for a bounded number of bytes and then discards the remainder. Matches found there are tagged with the main packet's index. While one bank is in use, the other bank can be reloaded. A swap request then flips to the reloaded bank at the next packet boundary and restarts the walk in state 0.

Top module: `dfa_byte_matcher`

## Requirements
- R1: After reset the walk is in state 0 and bank 0 is active (`act_bank`=0). No report is raised and `in_ready` is high.
- R2: A word carries `in_nbytes` valid bytes, from 1 to 8. They are consumed from bits [7:0] upward. The walk continues across the words of one packet until a word with `in_last`=1.
- R3: Each scanned byte triggers one table read at address {bank, state, byte}, with bank as the MSB and byte as the low 8 bits. Read data is valid 2 cycles after the read. The next byte is not looked up before the previous result has been applied.
- R4: The table entry is laid out as follows. The next state occupies the low 3 bits, bit 3 is the output flag, and bits 7:4 hold the pattern ID. When the flag is set, `m_valid` pulses for one cycle with `m_pid`. `m_pkt` is the `in_pkt` value of the main packet.
- R5: Every new main packet starts its walk in state 0, whatever state the previous packet ended in.
- R6: After the last byte of a main packet, the walk keeps its state into the following spill segment and scans up to `spill_max` bytes of it. Reports found there carry `m_spill`=1 and the main packet's index.
- R7: Spill bytes beyond `spill_max` are dropped without lookup, through the segment's `in_last`, even across words. With `spill_max`=0 the spill segment produces no report.
- R8: A `swap_req` pulse toggles `act_bank` and restarts the walk in state 0. A request that arrives after the first byte of a main packet has been looked up is held until that packet and its spill segment are done.
- R9: A table entry that was never written reads as zero. It therefore sends the walk to state 0 and raises no report.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tbl_we | input | 1 | Table write strobe |
| tbl_waddr | input | 12 | Table write address {bank, state, byte} |
| tbl_wdata | input | 8 | Table entry {pattern ID, output flag, next state} |
| swap_req | input | 1 | Request to switch to the other bank |
| spill_max | input | 12 | Maximum spill bytes to scan, sampled at main packet end |
| in_valid | input | 1 | Payload word valid |
| in_ready | output | 1 | Payload word accepted when high with in_valid |
| in_data | input | 64 | Payload word, first byte in bits [7:0] |
| in_nbytes | input | 4 | Number of valid bytes in the word (1..8) |
| in_last | input | 1 | Word ends the packet or spill segment |
| in_pkt | input | 8 | Packet index |
| m_valid | output | 1 | Match report strobe |
| m_pid | output | 4 | Matched pattern ID |
| m_pkt | output | 8 | Main packet index of the match |
| m_spill | output | 1 | Match was found in spill bytes |
| act_bank | output | 1 | Currently active table bank |

## Verification
On every cycle, the assertions check the following. A report only follows returned read data. Read data only follows a read issued two cycles earlier. The spill byte count never passes its latched limit. The active bank stays put while a main packet is open and the walk is in state 0 whenever the bank changes. Input word byte counts must be legal. The bench's scenarios are what show the actual match semantics. These include which patterns fire, across word and packet boundaries, the state reset at each new packet, the dropping of excess spill bytes, and a swap that is deferred to the packet boundary.

// File: rtl/dfa_pkg.sv
`timescale 1ns/1ps
package dfa_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [0:0] {
    PH_MAIN  = 1'b0,
    PH_SPILL = 1'b1
  } phase_e;
endpackage

// File: rtl/dfa_table_ram.sv
`timescale 1ns/1ps
// Two-bank transition store: one write port, one read port with
// a registered array read plus an output register (2-cycle latency).
module dfa_table_ram #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rd_q1;
  logic              v_q1;

  // Power-up contents: all-zero entries mean "fall back to state 0".
  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rd_q1 <= mem[raddr];
    rdata <= rd_q1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q1   <= 1'b0;
      rvalid <= 1'b0;
    end else begin
      v_q1   <= rd_en;
      rvalid <= v_q1;
    end
  end

  // R3: data is flagged valid exactly two cycles after a read request
  p_rd_latency_r3: assert property (@(posedge clk) disable iff (rst)
    rvalid |-> $past(rd_en, 2));
endmodule

// File: rtl/dfa_byte_feed.sv
`timescale 1ns/1ps
// Holds one payload word and hands its valid bytes out one at a time.
module dfa_byte_feed #(
  parameter int WORD_BYTES = 8,
  parameter int PKT_W      = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [8*WORD_BYTES-1:0] in_data,
  input  logic [$clog2(WORD_BYTES+1)-1:0] in_nbytes,
  input  logic                    in_last,
  input  logic [PKT_W-1:0]        in_pkt,
  output logic                    b_valid,
  output logic [7:0]              b_data,
  output logic                    b_last,
  output logic [PKT_W-1:0]        b_pkt,
  input  logic                    b_take
);
  localparam int NB_W  = $clog2(WORD_BYTES + 1);
  localparam int PTR_W = $clog2(WORD_BYTES);

  logic                    full;
  logic [8*WORD_BYTES-1:0] word_q;
  logic [NB_W-1:0]         cnt_q;
  logic [PTR_W-1:0]        ptr_q;
  logic                    last_q;
  logic [PKT_W-1:0]        pkt_q;
  logic [7:0]              lane [WORD_BYTES];
  logic                    end_of_word;

  for (genvar g = 0; g < WORD_BYTES; g++) begin : g_lane
    assign lane[g] = word_q[8*g +: 8];
  end

  assign in_ready    = !full;
  assign end_of_word = (NB_W'(ptr_q) + NB_W'(1)) == cnt_q;
  assign b_valid     = full;
  assign b_data      = lane[ptr_q];
  assign b_last      = last_q && end_of_word;
  assign b_pkt       = pkt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      full   <= 1'b0;
      word_q <= '0;
      cnt_q  <= '0;
      ptr_q  <= '0;
      last_q <= 1'b0;
      pkt_q  <= '0;
    end else if (in_valid && in_ready) begin
      full   <= 1'b1;
      word_q <= in_data;
      cnt_q  <= in_nbytes;
      ptr_q  <= '0;
      last_q <= in_last;
      pkt_q  <= in_pkt;
    end else if (b_take) begin
      if (end_of_word) full <= 1'b0;
      else ptr_q <= ptr_q + PTR_W'(1);
    end
  end

  // R2: an accepted word carries between one and WORD_BYTES bytes
  p_nbytes_legal_r2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |-> (in_nbytes != '0 && int'(in_nbytes) <= WORD_BYTES));

  // R2: bytes are only consumed while a word is held
  p_take_held_r2: assert property (@(posedge clk) disable iff (rst)
    b_take |-> full);
endmodule

// File: rtl/dfa_walk_ctrl.sv
`timescale 1ns/1ps
// Automaton walker: issues one table lookup per byte, applies the result,
// tracks main/spill phase, spill budget, bank selection and match reports.
module dfa_walk_ctrl
  import dfa_pkg::*;
#(
  parameter int STATE_W = 3,
  parameter int PID_W   = 4,
  parameter int PKT_W   = 8,
  parameter int SPILL_W = 12
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        b_valid,
  input  logic [BYTE_W-1:0]           b_data,
  input  logic                        b_last,
  input  logic [PKT_W-1:0]            b_pkt,
  output logic                        b_take,
  output logic                        rd_en,
  output logic [STATE_W+BYTE_W:0]     raddr,
  input  logic [PID_W+STATE_W:0]      rdata,
  input  logic                        rvalid,
  input  logic                        swap_req,
  input  logic [SPILL_W-1:0]          spill_max,
  output logic                        m_valid,
  output logic [PID_W-1:0]            m_pid,
  output logic [PKT_W-1:0]            m_pkt,
  output logic                        m_spill,
  output logic                        act_bank
);
  phase_e             phase;
  logic [STATE_W-1:0] cur_state;
  logic               bank;
  logic               swap_pend;
  logic               busy;
  logic               fl_last;
  logic               main_open;
  logic [SPILL_W-1:0] spill_cnt;
  logic [SPILL_W-1:0] spill_lim_q;
  logic [PKT_W-1:0]   main_pkt;

  logic [STATE_W-1:0] nxt_state;
  logic               hit;
  logic [PID_W-1:0]   hit_pid;
  logic               spill_room;
  logic               do_swap;
  logic               do_look;
  logic               do_drop;

  assign nxt_state = rdata[STATE_W-1:0];
  assign hit       = rdata[STATE_W];
  assign hit_pid   = rdata[STATE_W+1 +: PID_W];

  always_comb begin
    spill_room = spill_cnt < spill_lim_q;
    do_swap    = swap_pend && (phase == PH_MAIN) && !main_open && !busy;
    do_look    = b_valid && !busy && !do_swap && ((phase == PH_MAIN) || spill_room);
    do_drop    = b_valid && !busy && (phase == PH_SPILL) && !spill_room;
    b_take     = do_look || do_drop;
    rd_en      = do_look;
    raddr      = {bank, cur_state, b_data};
  end

  assign act_bank = bank;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase       <= PH_MAIN;
      cur_state   <= '0;
      bank        <= 1'b0;
      swap_pend   <= 1'b0;
      busy        <= 1'b0;
      fl_last     <= 1'b0;
      main_open   <= 1'b0;
      spill_cnt   <= '0;
      spill_lim_q <= '0;
      main_pkt    <= '0;
      m_valid     <= 1'b0;
      m_pid       <= '0;
      m_pkt       <= '0;
      m_spill     <= 1'b0;
    end else begin
      m_valid   <= 1'b0;
      swap_pend <= do_swap ? swap_req : (swap_pend || swap_req);

      if (do_swap) begin
        bank      <= ~bank;
        cur_state <= '0;
      end

      if (do_look) begin
        busy    <= 1'b1;
        fl_last <= b_last;
        if (phase == PH_MAIN) begin
          main_open <= 1'b1;
          main_pkt  <= b_pkt;
        end
      end

      if (do_drop && b_last) begin
        phase     <= PH_MAIN;
        main_open <= 1'b0;
        cur_state <= '0;
      end

      if (rvalid) begin
        busy      <= 1'b0;
        cur_state <= nxt_state;
        m_valid   <= hit;
        m_pid     <= hit_pid;
        m_pkt     <= main_pkt;
        m_spill   <= (phase == PH_SPILL);
        if (phase == PH_MAIN) begin
          if (fl_last) begin
            phase       <= PH_SPILL;
            spill_cnt   <= '0;
            spill_lim_q <= spill_max;
          end
        end else begin
          spill_cnt <= spill_cnt + SPILL_W'(1);
          if (fl_last) begin
            phase     <= PH_MAIN;
            main_open <= 1'b0;
            cur_state <= '0;
          end
        end
      end
    end
  end

  // R4: a report is only raised right after table data returned
  p_report_after_read_r4: assert property (@(posedge clk) disable iff (rst)
    m_valid |-> $past(rvalid));

  // R6: spill scanning never exceeds its latched byte budget
  p_spill_bound_r6: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_SPILL) |-> (spill_cnt <= spill_lim_q));

  // R8: the bank cannot change while a main packet is being walked
  p_bank_holds_r8: assert property (@(posedge clk) disable iff (rst)
    (main_open && $past(main_open)) |-> $stable(bank));

  // R8: a bank change always leaves the walk in state 0
  p_swap_restart_r8: assert property (@(posedge clk) disable iff (rst)
    (bank != $past(bank)) |-> (cur_state == '0));
endmodule

// File: rtl/dfa_byte_matcher.sv
`timescale 1ns/1ps
module dfa_byte_matcher #(
  parameter int STATE_W    = 3,
  parameter int PID_W      = 4,
  parameter int PKT_W      = 8,
  parameter int SPILL_W    = 12,
  parameter int WORD_BYTES = 8,
  localparam int ADDR_W    = 1 + STATE_W + 8,
  localparam int ENTRY_W   = PID_W + 1 + STATE_W,
  localparam int NB_W      = $clog2(WORD_BYTES + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    tbl_we,
  input  logic [ADDR_W-1:0]       tbl_waddr,
  input  logic [ENTRY_W-1:0]      tbl_wdata,
  input  logic                    swap_req,
  input  logic [SPILL_W-1:0]      spill_max,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [8*WORD_BYTES-1:0] in_data,
  input  logic [NB_W-1:0]         in_nbytes,
  input  logic                    in_last,
  input  logic [PKT_W-1:0]        in_pkt,
  output logic                    m_valid,
  output logic [PID_W-1:0]        m_pid,
  output logic [PKT_W-1:0]        m_pkt,
  output logic                    m_spill,
  output logic                    act_bank
);
  logic               b_valid;
  logic [7:0]         b_data;
  logic               b_last;
  logic [PKT_W-1:0]   b_pkt;
  logic               b_take;
  logic               rd_en;
  logic [ADDR_W-1:0]  raddr;
  logic [ENTRY_W-1:0] rdata;
  logic               rvalid;

  dfa_byte_feed #(.WORD_BYTES(WORD_BYTES), .PKT_W(PKT_W)) u_feed (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_nbytes(in_nbytes), .in_last(in_last), .in_pkt(in_pkt),
    .b_valid(b_valid), .b_data(b_data), .b_last(b_last), .b_pkt(b_pkt),
    .b_take(b_take)
  );

  dfa_walk_ctrl #(.STATE_W(STATE_W), .PID_W(PID_W), .PKT_W(PKT_W),
                  .SPILL_W(SPILL_W)) u_walk (
    .clk(clk), .rst(rst),
    .b_valid(b_valid), .b_data(b_data), .b_last(b_last), .b_pkt(b_pkt),
    .b_take(b_take),
    .rd_en(rd_en), .raddr(raddr), .rdata(rdata), .rvalid(rvalid),
    .swap_req(swap_req), .spill_max(spill_max),
    .m_valid(m_valid), .m_pid(m_pid), .m_pkt(m_pkt), .m_spill(m_spill),
    .act_bank(act_bank)
  );

  dfa_table_ram #(.ADDR_W(ADDR_W), .DATA_W(ENTRY_W)) u_tbl (
    .clk(clk), .rst(rst),
    .we(tbl_we), .waddr(tbl_waddr), .wdata(tbl_wdata),
    .rd_en(rd_en), .raddr(raddr), .rdata(rdata), .rvalid(rvalid)
  );
endmodule

// File: tb/dfa_byte_matcher_tb.sv
`timescale 1ns/1ps
module dfa_byte_matcher_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tbl_we = 1'b0;
  logic [11:0] tbl_waddr = '0;
  logic [7:0]  tbl_wdata = '0;
  logic        swap_req = 1'b0;
  logic [11:0] spill_max = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_data = '0;
  logic [3:0]  in_nbytes = '0;
  logic        in_last = 1'b0;
  logic [7:0]  in_pkt = '0;
  logic        m_valid;
  logic [3:0]  m_pid;
  logic [7:0]  m_pkt;
  logic        m_spill;
  logic        act_bank;

  always #2.5 clk = ~clk;

  dfa_byte_matcher u_dut (
    .clk(clk), .rst(rst), .tbl_we(tbl_we), .tbl_waddr(tbl_waddr),
    .tbl_wdata(tbl_wdata), .swap_req(swap_req), .spill_max(spill_max),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_nbytes(in_nbytes), .in_last(in_last), .in_pkt(in_pkt),
    .m_valid(m_valid), .m_pid(m_pid), .m_pkt(m_pkt), .m_spill(m_spill),
    .act_bank(act_bank)
  );

  // Vector table: main word, its byte count, spill word, its count,
  // spill budget, expected report count, first pid, first spill flag.
  localparam int NV = 7;
  localparam logic [63:0] V_MD [NV] = '{64'h636261, 64'h626171, 64'h6171,
    64'h79787978, 64'h797863626161, 64'h6261, 64'h7163};
  localparam int V_MN [NV] = '{3, 3, 2, 4, 6, 2, 2};
  localparam logic [63:0] V_SD [NV] = '{64'h71, 64'h7163, 64'h6362,
    64'h71, 64'h71, 64'h7163, 64'h71};
  localparam int V_SN [NV] = '{1, 2, 2, 1, 1, 2, 1};
  localparam int V_SM [NV] = '{2, 2, 1, 0, 3, 0, 0};
  localparam int V_EN [NV] = '{1, 1, 0, 2, 2, 0, 0};
  localparam int V_EP [NV] = '{1, 1, 0, 2, 1, 0, 0};
  localparam int V_ES [NV] = '{0, 1, 0, 0, 0, 0, 0};

  int total = 0;
  int bad = 0;
  int rtot = 0;
  bit timed_out = 0;
  int rec_pid [64];
  int rec_pkt [64];
  int rec_sp  [64];

  always @(negedge clk) begin
    if (!rst && m_valid) begin
      if (rtot < 64) begin
        rec_pid[rtot] = int'(m_pid);
        rec_pkt[rtot] = int'(m_pkt);
        rec_sp[rtot]  = int'(m_spill);
      end
      rtot = rtot + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
    end
  endtask

  function automatic string vtag(int i);
    case (i)
      1: return "R6";
      2, 5: return "R7";
      3: return "R3";
      4: return "R2";
      6: return "R5";
      default: return "R4";
    endcase
  endfunction

  task automatic wr(input int b, input int s, input int ch, input int nx,
                    input int fl, input int pid);
    tbl_we    = 1'b1;
    tbl_waddr = {b[0], s[2:0], ch[7:0]};
    tbl_wdata = {pid[3:0], fl[0], nx[2:0]};
    @(negedge clk);
    tbl_we    = 1'b0;
  endtask

  task automatic send(input logic [63:0] d, input int n, input bit last,
                      input int pkt);
    while (!in_ready) @(negedge clk);
    in_valid  = 1'b1;
    in_data   = d;
    in_nbytes = n[3:0];
    in_last   = last;
    in_pkt    = pkt[7:0];
    @(negedge clk);
    in_valid  = 1'b0;
  endtask

  task automatic pulse_swap();
    swap_req = 1'b1;
    @(negedge clk);
    swap_req = 1'b0;
  endtask

  // One main packet and its spill segment, then compare reports.
  task automatic scen(input logic [63:0] md, input int mn, input logic [63:0] sd,
                      input int sn, input int sm, input int pkt, input string tag,
                      input int en, input int ep, input int es);
    int base;
    base = rtot;
    spill_max = sm[11:0];
    send(md, mn, 1'b1, pkt);
    send(sd, sn, 1'b1, pkt + 1);
    repeat (80) @(negedge clk);
    chk(rtot - base == en, tag, "report count", rtot - base, en);
    if (en > 0 && rtot > base) begin
      chk(rec_pid[base] == ep, "R4", "pattern id", rec_pid[base], ep);
      chk(rec_pkt[base] == pkt, "R4", "packet index", rec_pkt[base], pkt);
      chk(rec_sp[base] == es, "R6", "spill flag", rec_sp[base], es);
    end
  endtask

  task automatic run_all();
    int base;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(in_ready == 1'b1, "R1", "in_ready", in_ready, 1);
    chk(m_valid == 1'b0, "R1", "m_valid", m_valid, 0);
    chk(act_bank == 1'b0, "R1", "act_bank", act_bank, 0);

    // R9: untouched table gives no reports
    scen(64'h636261, 3, 64'h71, 1, 2, 5, "R9", 0, 0, 0);

    // Bank 0: "abc" -> pid 1 (states 1,2,3), "xy" -> pid 2 (states 4,5)
    for (int s = 0; s < 6; s++) begin
      wr(0, s, 8'h61, 1, 0, 0);
      wr(0, s, 8'h78, 4, 0, 0);
    end
    wr(0, 1, 8'h62, 2, 0, 0);
    wr(0, 2, 8'h63, 3, 1, 1);
    wr(0, 4, 8'h79, 5, 1, 2);

    for (int v = 0; v < NV; v++) begin
      scen(V_MD[v], V_MN[v], V_SD[v], V_SN[v], V_SM[v], 10 + v, vtag(v),
           V_EN[v], V_EP[v], V_ES[v]);
    end

    // R2: pattern crossing a word boundary inside one packet
    base = rtot;
    spill_max = 12'd0;
    send(64'h6171717171717171, 8, 1'b0, 30);
    send(64'h6362, 2, 1'b1, 30);
    send(64'h71, 1, 1'b1, 31);
    repeat (80) @(negedge clk);
    chk(rtot - base == 1, "R2", "cross-word report count", rtot - base, 1);
    if (rtot > base) chk(rec_pid[base] == 1, "R2", "cross-word pid", rec_pid[base], 1);

    // R7: spill budget 1, remaining bytes and next word dropped
    base = rtot;
    spill_max = 12'd1;
    send(64'h7871717171717171, 8, 1'b1, 40);
    send(64'h7171717171797879, 8, 1'b0, 41);
    send(64'h7978, 2, 1'b1, 41);
    repeat (80) @(negedge clk);
    chk(rtot - base == 1, "R7", "drained spill report count", rtot - base, 1);
    if (rtot > base) begin
      chk(rec_sp[base] == 1, "R6", "spill flag", rec_sp[base], 1);
      chk(rec_pkt[base] == 40, "R6", "spill pkt index", rec_pkt[base], 40);
    end

    // R8: load bank 1 with "zz" -> pid 5, swap while idle
    wr(1, 0, 8'h7A, 6, 0, 0);
    wr(1, 6, 8'h7A, 7, 1, 5);
    wr(1, 7, 8'h7A, 7, 1, 5);
    pulse_swap();
    repeat (5) @(negedge clk);
    chk(act_bank == 1'b1, "R8", "bank after idle swap", act_bank, 1);
    scen(64'h7A7A7A, 3, 64'h71, 1, 0, 50, "R8", 2, 5, 0);
    // R9: bank 1 has no entries for "abc"
    scen(64'h636261, 3, 64'h71, 1, 0, 52, "R9", 0, 0, 0);

    // R8: swap requested mid-packet is deferred to the boundary
    base = rtot;
    spill_max = 12'd0;
    send(64'h7A71717171717171, 8, 1'b0, 60);
    pulse_swap();
    repeat (40) @(negedge clk);
    chk(act_bank == 1'b1, "R8", "bank held mid-packet", act_bank, 1);
    send(64'h7A, 1, 1'b1, 60);
    send(64'h71, 1, 1'b1, 61);
    repeat (80) @(negedge clk);
    chk(rtot - base == 1, "R8", "deferred swap report count", rtot - base, 1);
    if (rtot > base) chk(rec_pid[base] == 5, "R8", "deferred swap pid", rec_pid[base], 5);
    chk(act_bank == 1'b0, "R8", "bank after boundary", act_bank, 0);
    scen(64'h636261, 3, 64'h71, 1, 0, 62, "R8", 1, 1, 0);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        timed_out = 1;
      end
    join_any
    if (timed_out) begin
      total++;
      bad++;
      $display("FAIL watchdog expired act=1 exp=0");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule